// File: doc/BRIEF.md
# DMA Register Readback Sequencer

This block answers processor reads from the DMA controller's data port. It keeps a seven-bit selection mask that decides which of seven internal values the processor sees: the status byte, the two bytes of the remaining-byte counter, and the two bytes of each of the two port address pointers. After the sequence is started, each completed read returns the next enabled value. The order is fixed and the sequence wraps around without end. A separate command makes only the next read return the status byte. Any read made while no sequence has been started also returns the status byte.

Command decoding happens upstream. The decoder turns port writes into single-cycle strobes: mask write, start sequence, and read status. The transfer engine drives the counter, the pointers and the two status flags as live values, so a read always shows the current state of the transfer. No other command touches the sequencer. A load of new addresses therefore leaves a running read sequence in place. The control is a four-state machine. S_IDLE means no sequence and no request, and reads return status. S_SEQ means a sequence is active and reads return the selected entry. S_STAT_IDLE and S_STAT_SEQ mean a status request is pending, and the suffix records which state to go back to.

The transitions are as follows. A start-sequence strobe moves any state to S_SEQ. A read-status strobe moves S_IDLE to S_STAT_IDLE and S_SEQ to S_STAT_SEQ. A completed read moves S_STAT_IDLE back to S_IDLE and S_STAT_SEQ back to S_SEQ. In S_SEQ, a completed read moves the entry pointer forward. A read counts as complete on the falling edge of the read strobe.

Top module: `dma_readback_seq`

## Requirements
- R1: After reset, the mask is 0x7F (all seven entries enabled) and no sequence or status request is pending.
- R2: The status byte is 00E1101T. Bit 5 (E) is 0 once `flag_done` is high and 1 otherwise. Bit 0 (T) equals `flag_moved`. Bits 4..1 are 1101, and bits 7..6 are 0.
- R3: While no sequence has been started and no status request is pending, `rd_data` is the status byte.
- R4: Mask bits 0..6 enable, in this order: status, counter low, counter high, port A low, port A high, port B low, port B high. A start-sequence strobe makes the next read return the lowest-numbered enabled entry.
- R5: Each completed read in an active sequence moves to the next higher enabled entry and skips disabled ones.
- R6: After the highest enabled entry, the next read returns the lowest enabled entry again.
- R7: Each entry shows the live value of its input at the time of the read. Low bytes are bits 7..0 and high bytes are bits 15..8.
- R8: A read-status strobe makes the next read return the status byte. The read after that returns the entry the sequence would have returned anyway.
- R9: A mask write moves the sequence position to the lowest entry enabled by the new mask. An active sequence stays active.
- R10: With a mask of zero, every read returns the status byte.
- R11: The position changes only when `rd_strobe` falls. While the strobe is held high and the inputs do not change, `rd_data` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_wr | input | 1 | One-cycle strobe that loads `mask_in` |
| mask_in | input | 7 | New read-selection mask |
| init_seq | input | 1 | One-cycle strobe that starts the read sequence |
| read_status | input | 1 | One-cycle strobe that makes the next read return status |
| rd_strobe | input | 1 | Processor read active; the read completes when it falls |
| byte_cnt | input | 16 | Live byte counter |
| addr_a | input | 16 | Live port A pointer |
| addr_b | input | 16 | Live port B pointer |
| flag_done | input | 1 | Full block has completed at least once |
| flag_moved | input | 1 | At least one byte has been transferred |
| rd_data | output | 8 | Read data byte |

## Verification
A wrong position pointer or a wrong state shows up on `rd_data` during the very next read. The processor then sees a byte from the wrong source, or a status byte where a counter or pointer byte was expected, or the reverse. An off-by-one in the skip logic shows up only with sparse masks, and only at the point where the sequence wraps. For this reason the bench runs sparse masks through several full loops. A pointer that moves forward in the middle of a read appears as a change in `rd_data` while the strobe is still held.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
    localparam int RB_DW = 8;

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_SEQ       = 2'd1,
        S_STAT_IDLE = 2'd2,
        S_STAT_SEQ  = 2'd3
    } rb_state_t;

    function automatic logic [RB_DW-1:0] status_byte(input logic done, input logic moved);
        return {2'b00, ~done, 4'b1101, moved};
    endfunction
endpackage

// File: rtl/dma_rb_rd_fall.sv
module dma_rb_rd_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_in,
    output logic rd_done
);
    logic rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_in;
    end

    assign rd_done = rd_q & ~rd_in;
endmodule

// File: rtl/dma_rb_ptr_pick.sv
module dma_rb_ptr_pick #(
    parameter int N  = 7,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] cur,
    output logic [IW-1:0] first_idx,
    output logic [IW-1:0] next_idx
);
    always_comb begin
        first_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) first_idx = IW'(i);
        end
    end

    always_comb begin
        next_idx = first_idx;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (IW'(i) > cur)) next_idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_rb_value_mux.sv
module dma_rb_value_mux #(
    parameter int DW    = 8,
    parameter int AW    = 16,
    parameter int WORDS = 3,
    parameter int BPW   = AW / DW,
    parameter int N     = 1 + WORDS * BPW,
    parameter int IW    = $clog2(N)
) (
    input  logic [DW-1:0]             status,
    input  logic [WORDS-1:0][AW-1:0]  words,
    input  logic [IW-1:0]             sel,
    output logic [DW-1:0]             dout
);
    logic [DW-1:0] entry [N];

    assign entry[0] = status;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            assign entry[1 + w * BPW + b] = words[w][b*DW +: DW];
        end
    end

    always_comb begin
        dout = entry[0];
        for (int i = 1; i < N; i++) begin
            if (sel == IW'(i)) dout = entry[i];
        end
    end
endmodule

// File: rtl/dma_readback_seq.sv
module dma_readback_seq #(
    parameter int AW    = 16,
    parameter int WORDS = 3,
    parameter int N     = 1 + WORDS * (AW / dma_rb_pkg::RB_DW),
    parameter int IW    = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mask_wr,
    input  logic [N-1:0]              mask_in,
    input  logic                      init_seq,
    input  logic                      read_status,
    input  logic                      rd_strobe,
    input  logic [AW-1:0]             byte_cnt,
    input  logic [AW-1:0]             addr_a,
    input  logic [AW-1:0]             addr_b,
    input  logic                      flag_done,
    input  logic                      flag_moved,
    output logic [dma_rb_pkg::RB_DW-1:0] rd_data
);
    import dma_rb_pkg::*;

    localparam logic [N-1:0] MASK_RST = '1;

    rb_state_t     state_q, state_d;
    logic [IW-1:0] ptr_q, ptr_d;
    logic [N-1:0]  mask_q, mask_d;
    logic [IW-1:0] first_idx, next_idx, sel;
    logic          rd_done;
    logic [RB_DW-1:0] stat;

    dma_rb_rd_fall u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_in   (rd_strobe),
        .rd_done (rd_done)
    );

    dma_rb_ptr_pick #(.N(N), .IW(IW)) u_pick (
        .mask      (mask_d),
        .cur       (ptr_q),
        .first_idx (first_idx),
        .next_idx  (next_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ptr_q   <= '0;
            mask_q  <= MASK_RST;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            mask_q  <= mask_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        mask_d  = mask_wr ? mask_in : mask_q;
        if (init_seq) begin
            state_d = S_SEQ;
            ptr_d   = first_idx;
        end else begin
            if (mask_wr) ptr_d = first_idx;
            if (read_status) begin
                unique case (state_q)
                    S_IDLE:      state_d = S_STAT_IDLE;
                    S_SEQ:       state_d = S_STAT_SEQ;
                    S_STAT_IDLE: state_d = S_STAT_IDLE;
                    S_STAT_SEQ:  state_d = S_STAT_SEQ;
                endcase
            end else if (rd_done) begin
                unique case (state_q)
                    S_IDLE:      state_d = S_IDLE;
                    S_SEQ:       if (!mask_wr) ptr_d = next_idx;
                    S_STAT_IDLE: state_d = S_IDLE;
                    S_STAT_SEQ:  state_d = S_SEQ;
                endcase
            end
        end
    end

    // Output logic
    always_comb begin
        stat = status_byte(flag_done, flag_moved);
        sel  = (state_q == S_SEQ) ? ptr_q : '0;
    end

    dma_rb_value_mux #(.DW(RB_DW), .AW(AW), .WORDS(WORDS), .N(N), .IW(IW)) u_mux (
        .status (stat),
        .words  ({addr_b, addr_a, byte_cnt}),
        .sel    (sel),
        .dout   (rd_data)
    );
endmodule

// File: rtl/dma_rb_checker.sv
module dma_rb_checker #(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mask_wr,
    input logic          init_seq,
    input logic          read_status,
    input logic          rd_strobe,
    input logic          flag_done,
    input logic          flag_moved,
    input logic [7:0]    rd_data,
    input logic [1:0]    state_q,
    input logic [IW-1:0] ptr_q,
    input logic [N-1:0]  mask_q
);
    logic seen_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_mask <= 1'b0;
        else if (mask_wr) seen_mask <= 1'b1;
    end

    assert_reset_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_mask |-> mask_q == {N{1'b1}});

    assert_status_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != 2'd1) |-> rd_data == {2'b00, ~flag_done, 4'b1101, flag_moved});

    assert_init_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_seq |=> (state_q == 2'd1) &&
                     ((mask_q & ((N'(1) << ptr_q) - N'(1))) == '0));

    assert_ptr_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '0) |-> mask_q[ptr_q]);

    assert_stat_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (read_status && !init_seq) |=> (state_q == 2'd2 || state_q == 2'd3));

    assert_hold_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !init_seq && !mask_wr) |=> $stable(ptr_q));
endmodule

bind dma_readback_seq dma_rb_checker #(.N(N), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_wr     (mask_wr),
    .init_seq    (init_seq),
    .read_status (read_status),
    .rd_strobe   (rd_strobe),
    .flag_done   (flag_done),
    .flag_moved  (flag_moved),
    .rd_data     (rd_data),
    .state_q     (state_q),
    .ptr_q       (ptr_q),
    .mask_q      (mask_q)
);

// File: tb/tb_dma_readback_seq.sv
module tb_dma_readback_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_wr = 1'b0;
    logic [6:0]  mask_in = '0;
    logic        init_seq = 1'b0;
    logic        read_status = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [15:0] byte_cnt = '0;
    logic [15:0] addr_a = '0;
    logic [15:0] addr_b = '0;
    logic        flag_done = 1'b0;
    logic        flag_moved = 1'b0;
    logic [7:0]  rd_data;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    // Bench model of the requirements
    logic [6:0] m_mask;
    bit         m_seq, m_stat;
    int         m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_readback_seq dut (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_in(mask_in),
        .init_seq(init_seq), .read_status(read_status), .rd_strobe(rd_strobe),
        .byte_cnt(byte_cnt), .addr_a(addr_a), .addr_b(addr_b),
        .flag_done(flag_done), .flag_moved(flag_moved), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_status();
        return {2'b00, ~flag_done, 1'b1, 1'b1, 1'b0, 1'b1, flag_moved};
    endfunction

    function automatic logic [7:0] entry_val(int idx);
        case (idx)
            1: return byte_cnt[7:0];
            2: return byte_cnt[15:8];
            3: return addr_a[7:0];
            4: return addr_a[15:8];
            5: return addr_b[7:0];
            6: return addr_b[15:8];
            default: return exp_status();
        endcase
    endfunction

    function automatic int nxt(logic [6:0] m, int p);
        for (int i = 1; i <= 7; i++) begin
            if (m[(p + i) % 7]) return (p + i) % 7;
        end
        return 0;
    endfunction

    function automatic logic [7:0] expected();
        if (m_seq && !m_stat) return entry_val(m_ptr);
        return exp_status();
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic do_mask(logic [6:0] m);
        mask_in = m; mask_wr = 1'b1;
        @(negedge clk);
        mask_wr = 1'b0;
        m_mask = m; m_ptr = nxt(m, 6);
    endtask

    task automatic do_init();
        init_seq = 1'b1;
        @(negedge clk);
        init_seq = 1'b0;
        m_seq = 1'b1; m_stat = 1'b0; m_ptr = nxt(m_mask, 6);
    endtask

    task automatic do_stat();
        read_status = 1'b1;
        @(negedge clk);
        read_status = 1'b0;
        m_stat = 1'b1;
    endtask

    task automatic do_read(string tag, int len);
        rd_strobe = 1'b1;
        #1;
        check(tag, rd_data, expected());
        for (int k = 1; k < len; k++) begin
            @(negedge clk);
            #1;
            check(tag, rd_data, expected());
        end
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        if (m_stat) m_stat = 1'b0;
        else if (m_seq) m_ptr = nxt(m_mask, m_ptr);
    endtask

    task automatic randomize_live();
        byte_cnt = 16'($urandom);
        addr_a   = 16'($urandom);
        addr_b   = 16'($urandom);
        flag_done  = 1'($urandom);
        flag_moved = 1'($urandom);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R3: watchdog expired, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        m_mask = 7'h7F; m_seq = 1'b0; m_stat = 1'b0; m_ptr = 0;
        byte_cnt = 16'h1234; addr_a = 16'hA5C3; addr_b = 16'h0F96;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2, R3: status after reset, both flag combinations
        #1 check("R1", rd_data, 8'h3A);
        do_read("R3", 2);
        flag_done = 1'b1; flag_moved = 1'b1;
        #1 check("R2", rd_data, 8'h1B);
        flag_done = 1'b0; flag_moved = 1'b1;
        #1 check("R2", rd_data, 8'h3B);

        // R4, R5, R6, R7: full mask loop and wrap (reset mask is 0x7F)
        do_init();
        for (int i = 0; i < 7; i++) do_read("R5", 1);
        do_read("R6", 1);
        for (int i = 0; i < 6; i++) do_read("R6", 1);

        // R9, R4: sparse mask, entries 1, 4, 6
        do_mask(7'b1010010);
        do_read("R9", 1);
        do_read("R5", 1);
        do_read("R5", 1);
        do_read("R6", 1);
        // R8: status interleaved in the sequence
        do_stat();
        do_read("R8", 1);
        do_read("R8", 1);
        // R4: init restarts at the lowest enabled entry
        do_init();
        do_read("R4", 1);

        // R11, R7: long read keeps its position; live value shows through
        do_mask(7'b0011000);
        rd_strobe = 1'b1;
        #1 check("R11", rd_data, addr_a[7:0]);
        @(negedge clk); #1 check("R11", rd_data, addr_a[7:0]);
        addr_a = 16'h5EED;
        #1 check("R7", rd_data, 8'hED);
        @(negedge clk); #1 check("R11", rd_data, 8'hED);
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        m_ptr = nxt(m_mask, m_ptr);
        #1 check("R5", rd_data, 8'h5E);

        // R10: zero mask
        do_mask(7'b0000000);
        for (int i = 0; i < 3; i++) do_read("R10", 1);
        do_init();
        do_read("R10", 2);

        // Random phase
        do_mask(7'h7F);
        for (int it = 0; it < 400; it++) begin
            int op;
            randomize_live();
            op = int'($urandom % 12);
            if (op == 0) do_mask(7'($urandom));
            else if (op == 1) do_init();
            else if (op == 2) do_stat();
            else do_read("R5", 1 + int'($urandom % 3));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule